// File: doc/BRIEF.md
# Column-Group Coincidence Checker

This block sits beside the sense amplifiers of a memory array that runs a parallel test mode. In that mode one write stores the same value into a whole group of columns on a word line. A later read brings all of those cells back at once. The checker decides whether every sensed bit of the chosen group holds the same value. If they all agree, it passes the common value on as read data. If any bit differs, it raises a coincidence flag and records the failure in a sticky error flag.

Columns are split into two interleaved groups, even and odd, and each has its own select line. Two separate detectors look for "all selected bits one" and "all selected bits zero". A mixed pattern is therefore never resolved by majority or by a wired logic function. It is always reported as a mismatch. The error latch is driven by phase and by mode:
- It only listens during the evaluate phase of a test-mode read.
- It is forced to zero on writes and in normal mode.
- It ignores the first cycles of each read, while slow sense outputs settle.

Top module: `colgrp_coinc_check`

## Requirements
- R1: Bit i belongs to the even group when i is even and to the odd group when i is odd. `sel_even_i` selects the even group and `sel_odd_i` selects the odd group. With both high every bit is selected. With neither high no bit is selected. Unselected bits never affect any output.
- R2: `coinc_o` is 0 in the same cycle when all selected bits are 1, when all are 0, or when no bit is selected.
- R3: `coinc_o` is 1 in the same cycle when the selected bits contain both a 0 and a 1.
- R4: The error flag `err_o` becomes 1 at a clock edge when all of these hold: `test_mode_i`=1, `rd_i`=1, `eval_i`=1, the settling window has passed, and `coinc_o`=1.
- R5: Once set, `err_o` stays 1 through later agreeing reads until `clear_i` is sampled high, which zeroes it at that edge. Asynchronous reset also zeroes it.
- R6: While `eval_i`=0 (precharge phase), a mismatch never sets `err_o` and never changes `data_o`.
- R7: At any edge where `rd_i`=0 (write) or `test_mode_i`=0 (normal mode), `err_o` is loaded with 0.
- R8: The cycles of a test-mode read are numbered 0, 1, 2 and so on, counting from the first cycle with `test_mode_i`&`rd_i` high. Cycles numbered below `SETTLE_CYCLES` neither set `err_o` nor update `data_o`.
- R9: At an edge in a settled, evaluate-phase, test-mode read, if at least one bit is selected and all selected bits agree, `data_o` takes the common value. Otherwise `data_o` holds. A mixed pattern never updates it.
- R10: After reset `err_o`=0 and `data_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bits_i | input | NUM_BITS | Sensed column values |
| sel_even_i | input | 1 | Selects the even-indexed columns |
| sel_odd_i | input | 1 | Selects the odd-indexed columns |
| test_mode_i | input | 1 | 1 = parallel test mode |
| rd_i | input | 1 | 1 = read cycle, 0 = write cycle |
| eval_i | input | 1 | 0 = precharge phase, 1 = evaluate phase |
| clear_i | input | 1 | Synchronous clear of the error flag |
| data_o | output | 1 | Last agreed read value |
| coinc_o | output | 1 | 1 = selected bits disagree |
| err_o | output | 1 | Sticky error flag |

## Verification
The bench targets the following corner cases, each with the failure a wrong design would show:
- A read that starts on a mismatch: a design without the settling blank would flag a false error in the first cycles.
- A mismatch held through the precharge phase: a latch that is not gated by phase would set.
- Unselected columns that disagree while the selected group agrees: a mask error would report coincidence or corrupt the data.
- An empty selection: it would otherwise look like agreement and overwrite `data_o`.
- A near-unanimous pattern with a single odd bit: a majority or wired resolution would return data instead of flagging it.
- Writes and normal mode after an error: the flag must drop there, and an agreeing read before `clear_i` must not drop it.

// File: rtl/colgrp_pkg.sv
package colgrp_pkg;
  // Result of the two unanimity detectors over the selected columns
  typedef struct packed {
    logic all_one;
    logic all_zero;
    logic any_sel;
  } det_t;
endpackage

// File: rtl/colgrp_mask.sv
module colgrp_mask #(
  parameter int NUM_BITS = 16
) (
  input  logic                sel_even_i,
  input  logic                sel_odd_i,
  output logic [NUM_BITS-1:0] mask_o
);
  for (genvar i = 0; i < NUM_BITS; i++) begin : g_col
    if (i % 2 == 0) begin : g_even
      assign mask_o[i] = sel_even_i;
    end else begin : g_odd
      assign mask_o[i] = sel_odd_i;
    end
  end
endmodule

// File: rtl/colgrp_detect.sv
module colgrp_detect
  import colgrp_pkg::*;
#(
  parameter int NUM_BITS = 16
) (
  input  logic [NUM_BITS-1:0] bits_i,
  input  logic [NUM_BITS-1:0] mask_i,
  output det_t                det_o,
  output logic                mismatch_o
);
  logic [NUM_BITS-1:0] one_ok, zero_ok;

  // unselected columns are forced to "agree" in both detectors
  assign one_ok  = bits_i | ~mask_i;
  assign zero_ok = ~bits_i | ~mask_i;

  assign det_o.all_one  = &one_ok;
  assign det_o.all_zero = &zero_ok;
  assign det_o.any_sel  = |mask_i;
  assign mismatch_o     = ~(det_o.all_one | det_o.all_zero);

  always_comb begin
    // both detectors fire only on an empty selection
    a_r2_dual_fire_empty: assert (!(det_o.all_one && det_o.all_zero) || !det_o.any_sel);
  end
endmodule

// File: rtl/colgrp_settle.sv
module colgrp_settle #(
  parameter int SETTLE_CYCLES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_act_i,
  output logic armed_o
);
  localparam int CW = (SETTLE_CYCLES < 1) ? 1 : $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          done;

  assign done    = (cnt_q >= LIM);
  assign armed_o = rd_act_i && done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!rd_act_i) cnt_q <= '0;
    else if (!done)     cnt_q <= cnt_q + 1'b1;
  end

  a_r8_armed_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |-> rd_act_i);
  a_r8_idle_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_act_i |=> (cnt_q == '0));
endmodule

// File: rtl/colgrp_err_latch.sv
module colgrp_err_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_act_i,
  input  logic clear_i,
  input  logic eval_i,
  input  logic armed_i,
  input  logic mismatch_i,
  output logic err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               err_o <= 1'b0;
    else if (!rd_act_i || clear_i)             err_o <= 1'b0; // clamp / clear
    else if (armed_i && eval_i && mismatch_i)  err_o <= 1'b1;
  end

  a_r7_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_act_i |=> !err_o);
  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && rd_act_i && !clear_i) |=> err_o);
  a_r6_eval_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(eval_i && armed_i));
endmodule

// File: rtl/colgrp_coinc_check.sv
module colgrp_coinc_check
  import colgrp_pkg::*;
#(
  parameter int NUM_BITS      = 16,
  parameter int SETTLE_CYCLES = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_BITS-1:0] bits_i,
  input  logic                sel_even_i,
  input  logic                sel_odd_i,
  input  logic                test_mode_i,
  input  logic                rd_i,
  input  logic                eval_i,
  input  logic                clear_i,
  output logic                data_o,
  output logic                coinc_o,
  output logic                err_o
);
  logic [NUM_BITS-1:0] mask;
  det_t                det;
  logic                mismatch, rd_act, armed, take;

  assign rd_act = test_mode_i && rd_i;

  colgrp_mask #(.NUM_BITS(NUM_BITS)) u_mask (
    .sel_even_i (sel_even_i),
    .sel_odd_i  (sel_odd_i),
    .mask_o     (mask)
  );

  colgrp_detect #(.NUM_BITS(NUM_BITS)) u_det (
    .bits_i     (bits_i),
    .mask_i     (mask),
    .det_o      (det),
    .mismatch_o (mismatch)
  );

  colgrp_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_act_i (rd_act),
    .armed_o  (armed)
  );

  colgrp_err_latch u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_act_i   (rd_act),
    .clear_i    (clear_i),
    .eval_i     (eval_i),
    .armed_i    (armed),
    .mismatch_i (mismatch),
    .err_o      (err_o)
  );

  assign coinc_o = mismatch;

  // data captured only on a settled, unanimous, non-empty evaluate
  assign take = armed && eval_i && det.any_sel && !mismatch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_o <= 1'b0;
    else if (take) data_o <= det.all_one;
  end

  a_r9_no_mixed_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> $past(!coinc_o && eval_i && rd_act));
  a_r4_err_needs_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(coinc_o && rd_act));
endmodule

// File: tb/sim_colgrp_coinc_check.sv
module sim_colgrp_coinc_check;
  localparam int NB = 8;
  localparam int ST = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] bits = '0;
  logic sel_e = 1'b0, sel_o = 1'b0, tm = 1'b0, rd = 1'b0, ev = 1'b0, clr = 1'b0;
  logic data, coinc, err;

  int checks = 0, errors = 0;
  bit m_err = 0, m_data = 0;
  int m_k = 0;
  bit done = 0;

  always #5 clk = ~clk;

  colgrp_coinc_check #(.NUM_BITS(NB), .SETTLE_CYCLES(ST)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bits_i(bits), .sel_even_i(sel_e), .sel_odd_i(sel_o),
    .test_mode_i(tm), .rd_i(rd), .eval_i(ev), .clear_i(clr),
    .data_o(data), .coinc_o(coinc), .err_o(err)
  );

  function automatic logic [NB-1:0] f_mask(bit se, bit so);
    logic [NB-1:0] m;
    for (int i = 0; i < NB; i++) m[i] = (i % 2 == 0) ? se : so;
    return m;
  endfunction

  function automatic bit f_mixed(logic [NB-1:0] b, logic [NB-1:0] m);
    return ((b & m) != '0) && ((~b & m) != '0);
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag, logic [NB-1:0] b, bit se, bit so, bit t, bit r, bit e, bit c);
    logic [NB-1:0] m;
    bit mix, act, armed;
    bits = b; sel_e = se; sel_o = so; tm = t; rd = r; ev = e; clr = c;
    m = f_mask(se, so);
    mix = f_mixed(b, m);
    #1 check({tag, " coinc"}, coinc, mix);
    @(posedge clk);
    act = t && r;
    armed = act && (m_k >= ST);
    if (!act || c) m_err = 0;
    else if (armed && e && mix) m_err = 1;
    if (armed && e && (m != '0) && !mix) m_data = ((b & m) != '0);
    m_k = act ? ((m_k < ST) ? m_k + 1 : m_k) : 0;
    @(negedge clk);
    check({tag, " err"}, err, m_err);
    check({tag, " data"}, data, m_data);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R10 err", err, 1'b0);
    check("R10 data", data, 1'b0);
    rst_n = 1'b1;

    // R8: read opens on a mismatch during evaluate; blanked cycles
    step("R8", 8'b1010_0110, 1, 0, 1, 1, 1, 0);
    step("R8", 8'b1010_0110, 1, 0, 1, 1, 1, 0);
    step("R1", 8'b0000_0000, 0, 0, 0, 0, 0, 0);
    // R1/R3: even group all ones, odd columns disagree
    step("R1", 8'b0101_0101, 1, 0, 1, 1, 1, 0);
    step("R1", 8'b0001_0101, 1, 0, 1, 1, 1, 0);
    step("R9", 8'b0101_0111, 1, 0, 1, 1, 1, 0);
    // R6: mismatch during precharge
    step("R6", 8'b0100_0101, 1, 0, 1, 1, 0, 0);
    step("R6", 8'b0111_1111, 1, 1, 1, 1, 0, 0);
    // R3/R4: single odd one out in a full selection
    step("R3", 8'b1111_1110, 1, 1, 1, 1, 1, 0);
    step("R4", 8'b1111_1110, 1, 1, 1, 1, 1, 0);
    // R5: agreeing read keeps the flag, then clear
    step("R5", 8'b0000_0000, 1, 1, 1, 1, 1, 0);
    step("R5", 8'b1010_1010, 0, 1, 1, 1, 1, 1);
    step("R2", 8'b1010_1010, 0, 1, 1, 1, 1, 0);
    // R7: set again then write / normal mode
    step("R4", 8'b0000_0011, 1, 1, 1, 1, 1, 0);
    step("R7", 8'b0000_0011, 1, 1, 1, 0, 1, 0);
    for (int i = 0; i < 4; i++) step("R8", 8'b0000_0011, 1, 1, 1, 1, 1, 0);
    step("R7", 8'b0000_0011, 1, 1, 0, 1, 1, 0);
    // R2: empty selection never updates data
    for (int i = 0; i < 4; i++) step("R2", 8'b1100_1010, 0, 0, 1, 1, 1, 0);
    step("R9", 8'b1111_1111, 0, 1, 1, 1, 1, 0);
    step("R2", 8'b0011_0101, 0, 0, 1, 1, 1, 0);

    for (int i = 0; i < 600; i++) begin
      logic [NB-1:0] b;
      int p = $urandom_range(0, 3);
      b = (p == 0) ? '0 : (p == 1) ? '1 : NB'($urandom);
      if ($urandom_range(0, 5) == 0) b[$urandom_range(0, NB-1)] ^= 1'b1;
      step("R4", b, 1'($urandom), 1'($urandom), $urandom_range(0, 7) != 0,
           $urandom_range(0, 5) != 0, 1'($urandom), $urandom_range(0, 15) == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule